// File: doc/BRIEF.md
# Decode-Stage Stall Controller

This block sits beside the decode stage of a seven-stage in-order pipeline. The pipeline has a split fetch, a single integer execute stage, a two-stage data memory and a three-stage pipelined floating-point unit. Each cycle the block compares the source registers of the instruction in decode against the destinations of older instructions that are still in flight. It stalls decode when such an older instruction cannot have its result ready for forwarding in time.

Two producer classes are too slow for forwarding. An integer load only has its data at the end of the second memory stage, so a reader stalls while the load sits in the integer execute stage or the first memory stage. A floating-point add, subtract or multiply only has its result after its third execute stage, so a reader stalls while the producer sits in the first or second FP stage. Integer ALU results are assumed to be forwarded and never cause a stall.

The block decides again from its inputs every cycle and inserts at most one bubble per cycle. A dependence that needs a two-cycle wait therefore shows up as two stalls in a row, and the bubble advancing through the pipe releases the stall. On a stall, the program counter and both fetch-side latches keep their contents, and a no-op with every write and memory enable cleared enters the stage after decode.

Top module: `id_hazard_ctl`

## Requirements
- R1: With decode valid, an integer source in use that equals the destination of a writing load in the integer execute stage raises all stall outputs in the same cycle.
- R2: With decode valid, an integer source in use that equals the destination of a writing load in the first memory stage raises all stall outputs. A load one instruction ahead therefore gives exactly two consecutive stall cycles.
- R3: A writing non-load integer instruction in the execute stage or the first memory stage never causes a stall, whatever its destination.
- R4: Integer register number 0 never causes a stall, even when a writing load targets it.
- R5: An FP source in use that equals the destination of a writing FP operation in the first FP stage raises all stall outputs.
- R6: An FP source in use that equals the destination of a writing FP operation in the second FP stage raises all stall outputs. An FP op one instruction ahead therefore gives exactly two consecutive stall cycles.
- R7: FP register number 0 stalls in the same way as any other FP register.
- R8: A source whose use flag is low, or a producer whose write enable is low, never causes a stall.
- R9: The PC hold, both fetch-latch holds and the bubble request are always equal. All four are low when decode is not valid, and they are high exactly once per cycle however many hazards are present.
- R10: The integer and FP register files are separate. An integer source never matches an FP destination, and an FP source never matches an integer load destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_ra | input | INT_AW | First integer source number |
| id_ra_used | input | 1 | First integer source is read |
| id_rb | input | INT_AW | Second integer source number |
| id_rb_used | input | 1 | Second integer source is read |
| id_fa | input | FP_AW | First FP source number |
| id_fa_used | input | 1 | First FP source is read |
| id_fb | input | FP_AW | Second FP source number |
| id_fb_used | input | 1 | Second FP source is read |
| ex_rd | input | INT_AW | Destination of the integer execute-stage instruction |
| ex_rd_wr | input | 1 | That instruction writes an integer register |
| ex_is_load | input | 1 | That instruction is a load |
| m1_rd | input | INT_AW | Destination of the first-memory-stage instruction |
| m1_rd_wr | input | 1 | That instruction writes an integer register |
| m1_is_load | input | 1 | That instruction is a load |
| fx1_fd | input | FP_AW | Destination of the FP-op in FP stage one |
| fx1_fd_wr | input | 1 | That FP op writes its destination |
| fx2_fd | input | FP_AW | Destination of the FP-op in FP stage two |
| fx2_fd_wr | input | 1 | That FP op writes its destination |
| pc_hold | output | 1 | Keep the program counter |
| f1f2_hold | output | 1 | Keep the fetch-1 to fetch-2 latch |
| f2id_hold | output | 1 | Keep the fetch-2 to decode latch |
| issue_bubble | output | 1 | Send a no-op with all enables cleared to the next stage |

## Verification
An integer load hazard and an FP-unit hazard can be present in the same cycle. This happens when a decoding instruction reads both register files, for example a store of an FP value whose address register comes from a recent load. The bench sets a writing load in the execute stage and a writing FP op in FP stage one at once, both matching the decoding sources. It then checks that the four controls give one stall, not two or a pulse pattern. It also walks both two-cycle waits cycle by cycle as the bubble advances, and checks that the stall drops in exactly the third cycle.

// File: rtl/idhz_pkg.sv
package idhz_pkg;
  // register-number widths of the two files
  localparam int INT_REGS = 32;
  localparam int FP_REGS  = 32;
  localparam int INT_AW   = $clog2(INT_REGS);
  localparam int FP_AW    = $clog2(FP_REGS);
  // sources read per register file by one instruction
  localparam int NUM_SRC  = 2;
  // in-flight stages whose result is not yet forwardable
  localparam int LOAD_WAIT_STAGES = 2;  // EX, M1
  localparam int FP_WAIT_STAGES   = 2;  // FP stage 1, FP stage 2
endpackage

// File: rtl/idhz_match.sv
module idhz_match #(
  parameter int AW        = 5,
  parameter bit ZERO_SAFE = 1'b1
) (
  input  logic [AW-1:0] src,
  input  logic          src_used,
  input  logic [AW-1:0] dst,
  input  logic          dst_wr,
  output logic          hit
);
  logic zero_src;

  generate
    if (ZERO_SAFE) begin : g_zero
      assign zero_src = (src == '0);
    end else begin : g_plain
      assign zero_src = 1'b0;
    end
  endgenerate

  always_comb hit = src_used && dst_wr && (src == dst) && !zero_src;
endmodule

// File: rtl/idhz_int_chk.sv
module idhz_int_chk #(
  parameter int AW  = 5,
  parameter int NS  = 2,
  parameter int NST = 2
) (
  input  logic [NS-1:0][AW-1:0]  src,
  input  logic [NS-1:0]          used,
  input  logic [NST-1:0][AW-1:0] dst,
  input  logic [NST-1:0]         wr,
  input  logic [NST-1:0]         is_load,
  output logic                   hit
);
  localparam int NPAIR = NS * NST;
  logic [NPAIR-1:0] pair_hit;

  for (genvar s = 0; s < NS; s++) begin : g_src
    for (genvar t = 0; t < NST; t++) begin : g_stage
      idhz_match #(.AW(AW), .ZERO_SAFE(1'b1)) u_m (
        .src      (src[s]),
        .src_used (used[s]),
        .dst      (dst[t]),
        .dst_wr   (wr[t] & is_load[t]),
        .hit      (pair_hit[s*NST+t])
      );
    end
  end

  always_comb hit = |pair_hit;
endmodule

// File: rtl/idhz_fp_chk.sv
module idhz_fp_chk #(
  parameter int AW  = 5,
  parameter int NS  = 2,
  parameter int NST = 2
) (
  input  logic [NS-1:0][AW-1:0]  src,
  input  logic [NS-1:0]          used,
  input  logic [NST-1:0][AW-1:0] dst,
  input  logic [NST-1:0]         wr,
  output logic                   hit
);
  localparam int NPAIR = NS * NST;
  logic [NPAIR-1:0] pair_hit;

  for (genvar s = 0; s < NS; s++) begin : g_src
    for (genvar t = 0; t < NST; t++) begin : g_stage
      // FP register 0 is an ordinary register
      idhz_match #(.AW(AW), .ZERO_SAFE(1'b0)) u_m (
        .src      (src[s]),
        .src_used (used[s]),
        .dst      (dst[t]),
        .dst_wr   (wr[t]),
        .hit      (pair_hit[s*NST+t])
      );
    end
  end

  always_comb hit = |pair_hit;
endmodule

// File: rtl/id_hazard_ctl.sv
module id_hazard_ctl
  import idhz_pkg::*;
#(
  parameter int INT_AW = idhz_pkg::INT_AW,
  parameter int FP_AW  = idhz_pkg::FP_AW
) (
  input  logic              id_valid,
  input  logic [INT_AW-1:0] id_ra,
  input  logic              id_ra_used,
  input  logic [INT_AW-1:0] id_rb,
  input  logic              id_rb_used,
  input  logic [FP_AW-1:0]  id_fa,
  input  logic              id_fa_used,
  input  logic [FP_AW-1:0]  id_fb,
  input  logic              id_fb_used,
  input  logic [INT_AW-1:0] ex_rd,
  input  logic              ex_rd_wr,
  input  logic              ex_is_load,
  input  logic [INT_AW-1:0] m1_rd,
  input  logic              m1_rd_wr,
  input  logic              m1_is_load,
  input  logic [FP_AW-1:0]  fx1_fd,
  input  logic              fx1_fd_wr,
  input  logic [FP_AW-1:0]  fx2_fd,
  input  logic              fx2_fd_wr,
  output logic              pc_hold,
  output logic              f1f2_hold,
  output logic              f2id_hold,
  output logic              issue_bubble
);
  // gather sources and producer stages into vectors (index 0 = youngest producer)
  logic [NUM_SRC-1:0][INT_AW-1:0]          int_src;
  logic [NUM_SRC-1:0]                      int_used;
  logic [NUM_SRC-1:0][FP_AW-1:0]           fp_src;
  logic [NUM_SRC-1:0]                      fp_used;
  logic [LOAD_WAIT_STAGES-1:0][INT_AW-1:0] ld_dst;
  logic [LOAD_WAIT_STAGES-1:0]             ld_wr;
  logic [LOAD_WAIT_STAGES-1:0]             ld_is;
  logic [FP_WAIT_STAGES-1:0][FP_AW-1:0]    fpu_dst;
  logic [FP_WAIT_STAGES-1:0]               fpu_wr;
  logic                                    int_hit;
  logic                                    fp_hit;
  logic                                    stall;

  always_comb begin
    int_src  = '{id_rb, id_ra};
    int_used = {id_rb_used, id_ra_used};
    fp_src   = '{id_fb, id_fa};
    fp_used  = {id_fb_used, id_fa_used};
    ld_dst   = '{m1_rd, ex_rd};
    ld_wr    = {m1_rd_wr, ex_rd_wr};
    ld_is    = {m1_is_load, ex_is_load};
    fpu_dst  = '{fx2_fd, fx1_fd};
    fpu_wr   = {fx2_fd_wr, fx1_fd_wr};
  end

  idhz_int_chk #(.AW(INT_AW), .NS(NUM_SRC), .NST(LOAD_WAIT_STAGES)) u_int (
    .src     (int_src),
    .used    (int_used),
    .dst     (ld_dst),
    .wr      (ld_wr),
    .is_load (ld_is),
    .hit     (int_hit)
  );

  idhz_fp_chk #(.AW(FP_AW), .NS(NUM_SRC), .NST(FP_WAIT_STAGES)) u_fp (
    .src  (fp_src),
    .used (fp_used),
    .dst  (fpu_dst),
    .wr   (fpu_wr),
    .hit  (fp_hit)
  );

  // one combined decision: never more than one bubble per cycle
  always_comb begin
    stall        = id_valid && (int_hit || fp_hit);
    pc_hold      = stall;
    f1f2_hold    = stall;
    f2id_hold    = stall;
    issue_bubble = stall;
  end
endmodule

// File: rtl/idhz_sva.sv
module idhz_sva #(
  parameter int INT_AW = 5,
  parameter int FP_AW  = 5
) (
  input logic              id_valid,
  input logic [INT_AW-1:0] id_ra,
  input logic              id_ra_used,
  input logic [INT_AW-1:0] id_rb,
  input logic              id_rb_used,
  input logic [FP_AW-1:0]  id_fa,
  input logic              id_fa_used,
  input logic [FP_AW-1:0]  id_fb,
  input logic              id_fb_used,
  input logic [INT_AW-1:0] ex_rd,
  input logic              ex_rd_wr,
  input logic              ex_is_load,
  input logic [INT_AW-1:0] m1_rd,
  input logic              m1_rd_wr,
  input logic              m1_is_load,
  input logic [FP_AW-1:0]  fx1_fd,
  input logic              fx1_fd_wr,
  input logic [FP_AW-1:0]  fx2_fd,
  input logic              fx2_fd_wr,
  input logic              pc_hold,
  input logic              f1f2_hold,
  input logic              f2id_hold,
  input logic              issue_bubble
);
  always_comb begin
    // R9
    holds_agree_chk: assert ((pc_hold == issue_bubble) && (f1f2_hold == issue_bubble)
                             && (f2id_hold == issue_bubble));
    // R9
    idle_quiet_chk: assert (id_valid || !issue_bubble);
    // R1
    load_ex_chk: assert (!(id_valid && id_ra_used && ex_rd_wr && ex_is_load
                           && (id_ra == ex_rd) && (id_ra != '0)) || issue_bubble);
    // R2
    load_m1_chk: assert (!(id_valid && id_rb_used && m1_rd_wr && m1_is_load
                           && (id_rb == m1_rd) && (id_rb != '0)) || issue_bubble);
    // R5
    fp_s1_chk: assert (!(id_valid && id_fa_used && fx1_fd_wr && (id_fa == fx1_fd))
                       || issue_bubble);
    // R6
    fp_s2_chk: assert (!(id_valid && id_fb_used && fx2_fd_wr && (id_fb == fx2_fd))
                       || issue_bubble);
    // R3
    alu_free_chk: assert (!(!ex_is_load && !m1_is_load && !id_fa_used && !id_fb_used)
                          || !issue_bubble);
    // R4
    zero_free_chk: assert (!((!id_ra_used || id_ra == '0) && (!id_rb_used || id_rb == '0)
                             && !id_fa_used && !id_fb_used) || !issue_bubble);
  end
endmodule

bind id_hazard_ctl idhz_sva #(.INT_AW(INT_AW), .FP_AW(FP_AW)) sva_i (.*);

// File: tb/id_hazard_ctl_tb.sv
module id_hazard_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  typedef struct packed {
    logic       v;
    logic [4:0] ra; logic rau; logic [4:0] rb; logic rbu;
    logic [4:0] fa; logic fau; logic [4:0] fb; logic fbu;
    logic [4:0] exd; logic exw; logic exl;
    logic [4:0] m1d; logic m1w; logic m1l;
    logic [4:0] x1d; logic x1w; logic [4:0] x2d; logic x2w;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  // v  ra  u  rb  u  fa  u  fb  u  exd w l  m1d w l  x1d w  x2d w  exp req
  localparam vec_t TBL [NV] = '{
    '{1'b1,5'd3,1'b1,5'd0,1'b0,5'd0,1'b0,5'd0,1'b0,5'd3,1'b1,1'b1,5'd0,1'b0,1'b0,5'd0,1'b0,5'd0,1'b0,1'b1,4'd1},  // R1 ra vs EX load
    '{1'b1,5'd1,1'b0,5'd7,1'b1,5'd0,1'b0,5'd0,1'b0,5'd7,1'b1,1'b1,5'd0,1'b0,1'b0,5'd0,1'b0,5'd0,1'b0,1'b1,4'd1},  // R1 rb vs EX load
    '{1'b1,5'd4,1'b1,5'd0,1'b0,5'd0,1'b0,5'd0,1'b0,5'd0,1'b0,1'b0,5'd4,1'b1,1'b1,5'd0,1'b0,5'd0,1'b0,1'b1,4'd2},  // R2 M1 load
    '{1'b1,5'd3,1'b1,5'd0,1'b0,5'd0,1'b0,5'd0,1'b0,5'd3,1'b1,1'b0,5'd0,1'b0,1'b0,5'd0,1'b0,5'd0,1'b0,1'b0,4'd3},  // R3 EX alu
    '{1'b1,5'd4,1'b1,5'd4,1'b1,5'd0,1'b0,5'd0,1'b0,5'd0,1'b0,1'b0,5'd4,1'b1,1'b0,5'd0,1'b0,5'd0,1'b0,1'b0,4'd3},  // R3 M1 alu
    '{1'b1,5'd0,1'b1,5'd0,1'b1,5'd0,1'b0,5'd0,1'b0,5'd0,1'b1,1'b1,5'd0,1'b1,1'b1,5'd0,1'b0,5'd0,1'b0,1'b0,4'd4},  // R4 r0
    '{1'b1,5'd0,1'b0,5'd0,1'b0,5'd2,1'b1,5'd0,1'b0,5'd0,1'b0,1'b0,5'd0,1'b0,1'b0,5'd2,1'b1,5'd0,1'b0,1'b1,4'd5},  // R5
    '{1'b1,5'd0,1'b0,5'd0,1'b0,5'd0,1'b0,5'd9,1'b1,5'd0,1'b0,1'b0,5'd0,1'b0,1'b0,5'd0,1'b0,5'd9,1'b1,1'b1,4'd6},  // R6
    '{1'b1,5'd0,1'b0,5'd0,1'b0,5'd0,1'b1,5'd0,1'b0,5'd0,1'b0,1'b0,5'd0,1'b0,1'b0,5'd0,1'b1,5'd0,1'b0,1'b1,4'd7},  // R7 f0
    '{1'b1,5'd3,1'b0,5'd0,1'b0,5'd0,1'b0,5'd0,1'b0,5'd3,1'b1,1'b1,5'd0,1'b0,1'b0,5'd0,1'b0,5'd0,1'b0,1'b0,4'd8},  // R8 unused src
    '{1'b1,5'd3,1'b1,5'd0,1'b0,5'd0,1'b0,5'd0,1'b0,5'd3,1'b0,1'b1,5'd0,1'b0,1'b0,5'd2,1'b0,5'd0,1'b0,1'b0,4'd8},  // R8 no write
    '{1'b1,5'd5,1'b1,5'd0,1'b0,5'd0,1'b0,5'd0,1'b0,5'd0,1'b0,1'b0,5'd0,1'b0,1'b0,5'd5,1'b1,5'd0,1'b0,1'b0,4'd10}, // R10 int src vs fp
    '{1'b1,5'd0,1'b0,5'd0,1'b0,5'd6,1'b1,5'd0,1'b0,5'd6,1'b1,1'b1,5'd0,1'b0,1'b0,5'd0,1'b0,5'd0,1'b0,1'b0,4'd10}, // R10 fp src vs load
    '{1'b0,5'd3,1'b1,5'd0,1'b0,5'd0,1'b0,5'd0,1'b0,5'd3,1'b1,1'b1,5'd0,1'b0,1'b0,5'd0,1'b0,5'd0,1'b0,1'b0,4'd9},  // R9 invalid decode
    '{1'b1,5'd8,1'b1,5'd0,1'b0,5'd1,1'b1,5'd0,1'b0,5'd8,1'b1,1'b1,5'd0,1'b0,1'b0,5'd1,1'b1,5'd0,1'b0,1'b1,4'd9}   // R9 both hazards
  };

  logic       clk = 1'b0;
  logic       id_valid;
  logic [4:0] id_ra, id_rb, id_fa, id_fb, ex_rd, m1_rd, fx1_fd, fx2_fd;
  logic       id_ra_used, id_rb_used, id_fa_used, id_fb_used;
  logic       ex_rd_wr, ex_is_load, m1_rd_wr, m1_is_load, fx1_fd_wr, fx2_fd_wr;
  logic       pc_hold, f1f2_hold, f2id_hold, issue_bubble;
  int         n_run = 0;
  int         n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  id_hazard_ctl dut_i (.*);

  task automatic put(input vec_t x);
    id_valid = x.v;
    id_ra = x.ra; id_ra_used = x.rau; id_rb = x.rb; id_rb_used = x.rbu;
    id_fa = x.fa; id_fa_used = x.fau; id_fb = x.fb; id_fb_used = x.fbu;
    ex_rd = x.exd; ex_rd_wr = x.exw; ex_is_load = x.exl;
    m1_rd = x.m1d; m1_rd_wr = x.m1w; m1_is_load = x.m1l;
    fx1_fd = x.x1d; fx1_fd_wr = x.x1w; fx2_fd = x.x2d; fx2_fd_wr = x.x2w;
  endtask

  task automatic check(input string tag, input logic exp);
    logic [3:0] got;
    got = {pc_hold, f1f2_hold, f2id_hold, issue_bubble};
    n_run++;
    if (got !== {4{exp}}) begin
      n_bad++;
      $display("FAIL %s: holds/bubble=%b expected=%b", tag, got, {4{exp}});
    end
  endtask

  initial begin
    vec_t z;
    z = '0;
    put(z);
    @(negedge clk); #1;
    check("R9 idle all-zero", 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      put(TBL[i]);
      #1;
      check($sformatf("R%0d vector %0d", TBL[i].req, i), TBL[i].exp);
    end

    // R2: load one ahead, consumer in decode; bubble then advances
    z = '0; z.v = 1'b1; z.ra = 5'd12; z.rau = 1'b1;
    z.exd = 5'd12; z.exw = 1'b1; z.exl = 1'b1;
    @(negedge clk); put(z); #1; check("R2 load dist1 cycle1", 1'b1);
    z.exd = 5'd0; z.exw = 1'b0; z.exl = 1'b0;
    z.m1d = 5'd12; z.m1w = 1'b1; z.m1l = 1'b1;
    @(negedge clk); put(z); #1; check("R2 load dist1 cycle2", 1'b1);
    z.m1d = 5'd0; z.m1w = 1'b0; z.m1l = 1'b0;
    @(negedge clk); put(z); #1; check("R2 load dist1 cycle3 released", 1'b0);

    // R6: FP op one ahead, stalls in stage 1 and stage 2 then releases
    z = '0; z.v = 1'b1; z.fb = 5'd20; z.fbu = 1'b1;
    z.x1d = 5'd20; z.x1w = 1'b1;
    @(negedge clk); put(z); #1; check("R5 fp dist1 cycle1", 1'b1);
    z.x1d = 5'd0; z.x1w = 1'b0; z.x2d = 5'd20; z.x2w = 1'b1;
    @(negedge clk); put(z); #1; check("R6 fp dist1 cycle2", 1'b1);
    z.x2d = 5'd0; z.x2w = 1'b0;
    @(negedge clk); put(z); #1; check("R6 fp dist1 cycle3 released", 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_run++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule